// File: doc/BRIEF.md
# Stereo Slewing Digital Attenuator

This block is a two-channel digital volume stage for signed 24-bit audio samples that arrive once per audio frame. Each channel has an 8-bit attenuation code. A code step is 0.375 dB, so 256 codes cover 0 dB down to -95.625 dB. The block never applies a new code in one jump. The code in effect walks toward the requested code by one step per frame, which keeps gain changes free of audible clicks.

In front of the gain stage, a routing select can feed both channels from one input. After the gain stage, each channel has a polarity invert and a hard mute. The mute is not ramped and takes effect on the next clock edge. The gain is split into two parts. The low four code bits index a sixteen-entry mantissa table that covers one 6 dB octave. The high four bits give an extra right shift. Each frame's result leaves the block on a registered output with a valid strobe.

Top module: `audvol_top`

## Requirements
- R1: A high `in_valid` on a clock edge makes `out_valid` high on the following cycle only. `out_valid` is low in every cycle that does not follow an `in_valid` cycle.
- R2: The channel output for frame sample x and applied code c is round(x·M[c[3:0]] / 2^(16+c[7:4])). Rounding adds 2^(15+c[7:4]) to the product and then shifts arithmetically right. M[0..15] = 65536, 62767, 60115, 57574, 55142, 52812, 50580, 48443, 46396, 44436, 42558, 40760, 39037, 37388, 35808, 34295. Code 0 is unity gain.
- R3: On each `in_valid` edge, the applied code of each channel moves by exactly one toward that channel's target code. It stays put when it already equals the target, so it never overshoots in either direction. The code does not change on edges without `in_valid`. A frame's sample is scaled by the code in effect before that frame's own step.
- R4: `mono_sel` 2'b00 feeds each channel from its own input. 2'b01 feeds both channels from the left input. 2'b10 feeds both channels from the right input. 2'b11 behaves like 2'b00. Each channel still applies its own code, invert and mute.
- R5: A channel's invert input negates that channel's scaled result. The result saturates to the signed 24-bit range, so -8388608 at unity gain becomes +8388607.
- R6: While a channel's mute input is high, that channel's output is 0 from the next clock edge onward, even without `in_valid`. Mute does not change the slewing of the applied code.
- R7: Synchronous active-high reset clears both outputs, clears `out_valid` and sets both applied codes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame strobe: one new sample per channel |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| target_left | input | 8 | Requested left attenuation code |
| target_right | input | 8 | Requested right attenuation code |
| mono_sel | input | 2 | Routing select (00 stereo, 01 left to both, 10 right to both, 11 stereo) |
| invert_left | input | 1 | Left polarity invert |
| invert_right | input | 1 | Right polarity invert |
| mute_left | input | 1 | Left immediate mute |
| mute_right | input | 1 | Right immediate mute |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Left output sample, signed |
| out_right | output | 24 | Right output sample, signed |
| code_left | output | 8 | Left code currently applied |
| code_right | output | 8 | Right code currently applied |

## Verification
The checker assumes that the target codes, routing select and invert inputs only change between frames, and that the input samples are meaningful only while `in_valid` is high. The stimulus therefore drives every control on the falling edge before a frame, and keeps `in_valid` to a single cycle with idle cycles in between. The unity-gain property is qualified on stereo routing with mute and invert low, so the cycles where routing or mute apply are left to the directed tests. The stimulus walks the codes up and down across octave boundaries, so rounding is exercised with both mantissa and shift nonzero.

// File: rtl/audvol_pkg.sv
package audvol_pkg;

    localparam int SAMPLE_W  = 24;
    localparam int CODE_W    = 8;
    localparam int STEP_BITS = 4;
    localparam int EXP_W     = CODE_W - STEP_BITS;
    localparam int FRAC_W    = 16;
    localparam int MANT_W    = FRAC_W + 1;
    localparam int NUM_CH    = 2;
    localparam int PROD_W    = SAMPLE_W + MANT_W + 1;
    localparam int SH_W      = $clog2(FRAC_W + (1 << EXP_W));

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [CODE_W-1:0]          code_t;
    typedef logic signed [PROD_W-1:0]   wide_t;

    typedef enum logic [1:0] {
        ROUTE_STEREO     = 2'b00,
        ROUTE_LEFT_BOTH  = 2'b01,
        ROUTE_RIGHT_BOTH = 2'b10,
        ROUTE_STEREO_ALT = 2'b11
    } route_e;

    typedef struct packed {
        logic invert;
        logic mute;
    } chan_ctrl_t;

    // One octave of 0.375 dB steps, unity = 2^FRAC_W
    function automatic logic [MANT_W-1:0] mant_lut(input logic [STEP_BITS-1:0] idx);
        logic [MANT_W-1:0] m;
        case (idx)
            4'd0:  m = 17'd65536;
            4'd1:  m = 17'd62767;
            4'd2:  m = 17'd60115;
            4'd3:  m = 17'd57574;
            4'd4:  m = 17'd55142;
            4'd5:  m = 17'd52812;
            4'd6:  m = 17'd50580;
            4'd7:  m = 17'd48443;
            4'd8:  m = 17'd46396;
            4'd9:  m = 17'd44436;
            4'd10: m = 17'd42558;
            4'd11: m = 17'd40760;
            4'd12: m = 17'd39037;
            4'd13: m = 17'd37388;
            4'd14: m = 17'd35808;
            default: m = 17'd34295;
        endcase
        return m;
    endfunction

    function automatic sample_t sat_to_sample(input wide_t v);
        wide_t hi;
        wide_t lo;
        hi = wide_t'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
        lo = -wide_t'(64'sd1 <<< (SAMPLE_W - 1));
        if (v > hi)
            return sample_t'(hi);
        else if (v < lo)
            return sample_t'(lo);
        else
            return v[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/audvol_route.sv
module audvol_route
    import audvol_pkg::*;
(
    input  route_e  mode,
    input  sample_t in_left,
    input  sample_t in_right,
    output sample_t src_left,
    output sample_t src_right
);

    always_comb begin
        unique case (mode)
            ROUTE_LEFT_BOTH: begin
                src_left  = in_left;
                src_right = in_left;
            end
            ROUTE_RIGHT_BOTH: begin
                src_left  = in_right;
                src_right = in_right;
            end
            default: begin
                src_left  = in_left;
                src_right = in_right;
            end
        endcase
    end

endmodule

// File: rtl/audvol_slew.sv
module audvol_slew
    import audvol_pkg::*;
#(
    parameter code_t RESET_CODE = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  code_t target,
    output code_t applied
);

    always_ff @(posedge clk) begin
        if (rst) begin
            applied <= RESET_CODE;
        end else if (step) begin
            if (applied < target)
                applied <= applied + code_t'(1);
            else if (applied > target)
                applied <= applied - code_t'(1);
        end
    end

endmodule

// File: rtl/audvol_gain.sv
module audvol_gain
    import audvol_pkg::*;
(
    input  sample_t x,
    input  code_t   code,
    input  logic    invert,
    output sample_t y
);

    logic [MANT_W-1:0] mant;
    logic [SH_W-1:0]   shamt;
    wide_t             xs;
    wide_t             ms;
    wide_t             prod;
    wide_t             half;
    wide_t             scaled;
    wide_t             signed_res;

    always_comb begin
        mant       = mant_lut(code[STEP_BITS-1:0]);
        shamt      = SH_W'(FRAC_W) + SH_W'(code[CODE_W-1:STEP_BITS]);
        xs         = wide_t'(x);
        ms         = wide_t'($signed({1'b0, mant}));
        prod       = xs * ms;
        half       = wide_t'(1) <<< (shamt - SH_W'(1));
        scaled     = (prod + half) >>> shamt;
        signed_res = invert ? -scaled : scaled;
        y          = sat_to_sample(signed_res);
    end

endmodule

// File: rtl/audvol_top.sv
module audvol_top
    import audvol_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic [CODE_W-1:0]          target_left,
    input  logic [CODE_W-1:0]          target_right,
    input  logic [1:0]                 mono_sel,
    input  logic                       invert_left,
    input  logic                       invert_right,
    input  logic                       mute_left,
    input  logic                       mute_right,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right,
    output logic [CODE_W-1:0]          code_left,
    output logic [CODE_W-1:0]          code_right
);

    sample_t    src    [NUM_CH];
    code_t      tgt    [NUM_CH];
    code_t      cur    [NUM_CH];
    sample_t    gained [NUM_CH];
    sample_t    held   [NUM_CH];
    chan_ctrl_t ctl    [NUM_CH];
    logic       valid_q;

    assign tgt[0] = target_left;
    assign tgt[1] = target_right;
    assign ctl[0] = '{invert: invert_left,  mute: mute_left};
    assign ctl[1] = '{invert: invert_right, mute: mute_right};

    audvol_route u_route (
        .mode      (route_e'(mono_sel)),
        .in_left   (in_left),
        .in_right  (in_right),
        .src_left  (src[0]),
        .src_right (src[1])
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        audvol_slew #(.RESET_CODE(RESET_CODE)) u_slew (
            .clk     (clk),
            .rst     (rst),
            .step    (in_valid),
            .target  (tgt[ch]),
            .applied (cur[ch])
        );

        audvol_gain u_gain (
            .x      (src[ch]),
            .code   (cur[ch]),
            .invert (ctl[ch].invert),
            .y      (gained[ch])
        );

        // Mute is checked every cycle, so it bypasses the frame strobe
        always_ff @(posedge clk) begin
            if (rst || ctl[ch].mute)
                held[ch] <= '0;
            else if (in_valid)
                held[ch] <= gained[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else
            valid_q <= in_valid;
    end

    assign out_valid  = valid_q;
    assign out_left   = held[0];
    assign out_right  = held[1];
    assign code_left  = cur[0];
    assign code_right = cur[1];

endmodule

// File: rtl/audvol_chk.sv
module audvol_chk
    import audvol_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic signed [SAMPLE_W-1:0] in_left,
    input logic [CODE_W-1:0]          target_left,
    input logic [CODE_W-1:0]          target_right,
    input logic [1:0]                 mono_sel,
    input logic                       invert_left,
    input logic                       mute_left,
    input logic                       mute_right,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] out_left,
    input logic signed [SAMPLE_W-1:0] out_right,
    input logic [CODE_W-1:0]          code_left,
    input logic [CODE_W-1:0]          code_right
);

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_only_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_unity_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_left == '0 && !invert_left && !mute_left && mono_sel == 2'b00)
        |=> out_left == $past(in_left));

    p_hold_code_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(code_left) && $stable(code_right)));

    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_left < target_left) |=> code_left == $past(code_left) + 8'd1);

    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_right > target_right) |=> code_right == $past(code_right) - 8'd1);

    p_park_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_left == target_left) |=> $stable(code_left));

    p_mute_left_r6: assert property (@(posedge clk) disable iff (rst)
        mute_left |=> out_left == '0);

    p_mute_right_r6: assert property (@(posedge clk) disable iff (rst)
        mute_right |=> out_right == '0);

endmodule

bind audvol_top audvol_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_left      (in_left),
    .target_left  (target_left),
    .target_right (target_right),
    .mono_sel     (mono_sel),
    .invert_left  (invert_left),
    .mute_left    (mute_left),
    .mute_right   (mute_right),
    .out_valid    (out_valid),
    .out_left     (out_left),
    .out_right    (out_right),
    .code_left    (code_left),
    .code_right   (code_right)
);

// File: tb/audvol_top_bench.sv
`timescale 1ns/1ps
module audvol_top_bench;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [23:0] in_left = '0;
    logic signed [23:0] in_right = '0;
    logic [7:0]         target_left = '0;
    logic [7:0]         target_right = '0;
    logic [1:0]         mono_sel = 2'b00;
    logic               invert_left = 1'b0;
    logic               invert_right = 1'b0;
    logic               mute_left = 1'b0;
    logic               mute_right = 1'b0;
    logic               out_valid;
    logic signed [23:0] out_left;
    logic signed [23:0] out_right;
    logic [7:0]         code_left;
    logic [7:0]         code_right;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    exp_cl   = 0;
    int    exp_cr   = 0;
    string out_tag  = "R2";

    always #2.5 clk = ~clk;

    audvol_top u_audvol_top (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .target_left(target_left), .target_right(target_right),
        .mono_sel(mono_sel), .invert_left(invert_left), .invert_right(invert_right),
        .mute_left(mute_left), .mute_right(mute_right),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .code_left(code_left), .code_right(code_right)
    );

    task automatic check(input string req, input string what, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic longint mant(input int k);
        case (k)
            0: return 65536;   1: return 62767;   2: return 60115;   3: return 57574;
            4: return 55142;   5: return 52812;   6: return 50580;   7: return 48443;
            8: return 46396;   9: return 44436;  10: return 42558;  11: return 40760;
           12: return 39037;  13: return 37388;  14: return 35808;  default: return 34295;
        endcase
    endfunction

    function automatic longint model(input longint x, input int c, input logic inv);
        longint p;
        longint r;
        int     sh;
        p  = x * mant(c % 16);
        sh = 16 + c / 16;
        r  = (p + (longint'(1) <<< (sh - 1))) >>> sh;
        if (inv) r = -r;
        if (r > 8388607)  r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    function automatic int step_toward(input int cur, input int tgt);
        if (cur < tgt) return cur + 1;
        if (cur > tgt) return cur - 1;
        return cur;
    endfunction

    // One frame: drive, let one edge pass, compare outputs and codes
    task automatic frame(input longint l, input longint r);
        longint sl;
        longint sr;
        longint el;
        longint er;
        sl = (mono_sel == 2'b10) ? r : l;
        sr = (mono_sel == 2'b01) ? l : r;
        el = mute_left  ? 0 : model(sl, exp_cl, invert_left);
        er = mute_right ? 0 : model(sr, exp_cr, invert_right);
        @(negedge clk);
        in_left  = l[23:0];
        in_right = r[23:0];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp_cl = step_toward(exp_cl, int'(target_left));
        exp_cr = step_toward(exp_cr, int'(target_right));
        check("R1", "out_valid", out_valid, 1);
        check(out_tag, "out_left", out_left, el);
        check(out_tag, "out_right", out_right, er);
        check("R3", "code_left", code_left, exp_cl);
        check("R3", "code_right", code_right, exp_cr);
    endtask

    task automatic t_reset;
        check("R7", "out_valid", out_valid, 0);
        check("R7", "out_left", out_left, 0);
        check("R7", "out_right", out_right, 0);
        check("R7", "code_left", code_left, 0);
        check("R7", "code_right", code_right, 0);
    endtask

    task automatic t_unity;
        out_tag = "R2";
        frame(1000, -2000);
        frame(-8388608, 8388607);
        @(negedge clk);
        check("R1", "out_valid idle", out_valid, 0);
    endtask

    task automatic t_slew;
        out_tag = "R3";
        target_left  = 8'd5;
        target_right = 8'd0;
        for (int i = 0; i < 7; i++) frame(4000000, -3000000);
        check("R3", "parked left", code_left, 5);
        repeat (6) @(negedge clk);
        check("R3", "idle hold", code_left, 5);
        target_left = 8'd2;
        for (int i = 0; i < 5; i++) frame(-4000001, 123457);
        check("R3", "parked after descent", code_left, 2);
    endtask

    task automatic t_gains;
        out_tag = "R2";
        target_left  = 8'd37;
        target_right = 8'd200;
        for (int i = 0; i < 205; i++)
            frame(longint'((i * 40961) % 8388607) - 4194304, 8388607 - longint'(i * 31337));
        target_left  = 8'd17;
        target_right = 8'd190;
        for (int i = 0; i < 22; i++)
            frame(-8388608 + longint'(i * 777), 5555555 - longint'(i));
    endtask

    task automatic t_mono;
        out_tag = "R4";
        mono_sel = 2'b01;
        frame(3000001, -7);
        frame(-1234567, 7654321);
        mono_sel = 2'b10;
        frame(3000001, -2999999);
        frame(8388607, -8388608);
        mono_sel = 2'b11;
        frame(-555555, 666666);
        mono_sel = 2'b00;
    endtask

    task automatic t_invert;
        out_tag = "R5";
        target_left  = 8'd0;
        target_right = 8'd0;
        for (int i = 0; i < 200; i++) frame(i * 11, -i * 13);
        invert_left  = 1'b1;
        invert_right = 1'b1;
        frame(-8388608, 12345);
        check("R5", "saturated code", code_left, 0);
        frame(8388607, -99);
        invert_left  = 1'b0;
        invert_right = 1'b0;
    endtask

    task automatic t_mute;
        out_tag = "R6";
        frame(2000000, 2000000);
        @(negedge clk);
        mute_left = 1'b1;
        @(negedge clk);
        check("R6", "mute without frame", out_left, 0);
        check("R6", "other channel kept", out_right, 2000000);
        target_left = 8'd4;
        for (int i = 0; i < 3; i++) frame(1500000, -1500000);
        check("R6", "slew under mute", code_left, 3);
        mute_left  = 1'b0;
        mute_right = 1'b1;
        frame(1500000, -1500000);
        mute_right = 1'b0;
        frame(-1, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_unity();
        t_slew();
        t_gains();
        t_mono();
        t_invert();
        t_mute();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule